// File: doc/BRIEF.md
# Sequential-Address One-Time-Programmable Byte Target

This block models the target side of a byte-wide one-time-programmable memory port. It lets a programmer design be tested against a counterpart that behaves like the memory. There is no address bus. An internal counter selects the current byte. A pulse on the clear input returns the counter to zero, and each rising edge of the step input moves it forward by one. The only way back to an earlier location is a clear followed by the right number of steps.

Every cell starts erased at all ones. When the read strobe is low, the addressed byte is driven onto the bus, and bus bit k carries stored bit k. A high bit means unprogrammed and a low bit means programmed. When the burn strobe returns high, the byte on the bus is ANDed into the addressed cell, so a programmed bit never returns to one. Every port action is ignored unless the mode enable from the unlock logic is high.

The port strobes come from a slow external programmer. They pass through a synchroniser of configurable depth and are then acted on as edges in the system clock domain. The bidirectional data pins are split into an input bus, an output bus and an output enable.

Top module: `otp_seq_target`

## Requirements
- R1: After the synchronous reset, the counter is at address 0, every cell holds 8'hFF and `bus_oe` is 0.
- R2: A rising edge on `ctr_clear` while enabled sets the counter to address 0.
- R3: A rising edge on `ctr_step` while enabled moves the counter from address a to a+1 when a is below the last address (DEPTH-1).
- R4: A step at the last address goes to address 0 when WRAP=1 and stays at the last address when WRAP=0; the counter never exceeds DEPTH-1.
- R5: While enabled with `read_n` low, `bus_oe` is 1 and `bus_out[k]` equals bit k of the addressed cell; with `read_n` high, `bus_oe` is 0.
- R6: A rising edge on `burn_n` (the end of a program pulse) stores old_byte AND `bus_in` into the addressed cell, so no bit goes from 0 to 1.
- R7: With `mode_en` low, clear, step and burn edges change neither the counter nor the cells, and `bus_oe` stays 0.
- R8: When clear and step edges arrive in the same cycle, the clear wins and the counter ends at address 0.
- R9: A burn edge that arrives while `read_n` is low (bus driven by the target) leaves the cells unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Programming-mode enable from the unlock logic |
| ctr_clear | input | 1 | Counter clear strobe, acted on at its rising edge |
| ctr_step | input | 1 | Counter advance strobe, acted on at its rising edge |
| read_n | input | 1 | Active-low read strobe |
| burn_n | input | 1 | Active-low program strobe; the write happens at its rising edge |
| bus_in | input | DW | Data from the bus pins |
| bus_out | output | DW | Addressed byte towards the bus pins |
| bus_oe | output | 1 | Output enable for the bus pins |

## Verification
The bench builds two copies of the block with DEPTH=8, one with WRAP=1 and one with WRAP=0, and drives both with the same stimulus. With only eight locations, the last address is reached after seven steps. The wrap and saturate cases can therefore be compared side by side, since the two copies read back different bytes after the extra step. A two-stage synchroniser keeps the strobe-to-action latency short, and every edge is held long enough for both copies to see it.

// File: rtl/otp_tgt_pkg.sv
package otp_tgt_pkg;

    typedef struct packed {
        logic clr_rise;
        logic step_rise;
        logic burn_done;
        logic rd_act;
    } port_evt_t;

    function automatic int unsigned adv_addr(int unsigned cur, int unsigned last, bit wrap);
        if (cur >= last) begin
            return wrap ? 0 : last;
        end
        return cur + 1;
    endfunction

endpackage

// File: rtl/otp_port_sync.sv
module otp_port_sync
    import otp_tgt_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr_i,
    input  logic          step_i,
    input  logic          rd_n_i,
    input  logic          burn_n_i,
    input  logic [DW-1:0] din,
    output port_evt_t     evt,
    output logic [DW-1:0] wdata
);
    localparam int VW = DW + 4;
    localparam int P_CLR  = VW - 1;
    localparam int P_STEP = VW - 2;
    localparam int P_RD   = VW - 3;
    localparam int P_BURN = VW - 4;
    localparam logic [VW-1:0] IDLE = {1'b0, 1'b0, 1'b1, 1'b1, {DW{1'b1}}};

    logic [VW-1:0] stg [STAGES];
    logic [VW-1:0] prev;
    logic [VW-1:0] cur;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stg
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= IDLE;
                    else     stg[g] <= {clr_i, step_i, rd_n_i, burn_n_i, din};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= IDLE;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign cur = stg[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= IDLE;
        else     prev <= cur;
    end

    always_comb begin
        evt.clr_rise  = en & cur[P_CLR]  & ~prev[P_CLR];
        evt.step_rise = en & cur[P_STEP] & ~prev[P_STEP];
        evt.burn_done = en & cur[P_BURN] & ~prev[P_BURN];
        evt.rd_act    = en & ~cur[P_RD];
        wdata         = cur[DW-1:0];
    end

endmodule

// File: rtl/otp_addr_ctr.sv
module otp_addr_ctr
    import otp_tgt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter bit WRAP  = 1'b1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (clr)  addr <= '0;
        else if (step) addr <= AW'(adv_addr(32'(addr), 32'(DEPTH - 1), WRAP));
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> addr == '0);

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && addr != LAST_A) |=> addr == $past(addr) + AW'(1));

    assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_A);

    assert_prio_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && step) |=> addr == '0);

    generate
        if (WRAP) begin : g_wrap
            assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
                (step && !clr && addr == LAST_A) |=> addr == '0);
        end else begin : g_sat
            assert_sat_R4: assert property (@(posedge clk) disable iff (rst)
                (step && !clr && addr == LAST_A) |=> addr == LAST_A);
        end
    endgenerate

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic          up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    assign rdata = mem[addr];

    generate
        for (genvar c = 0; c < DEPTH; c++) begin : g_chk
            assert_one_way_R6: assert property (@(posedge clk) disable iff (rst)
                up_q |-> (mem[c] & ~$past(mem[c])) == '0);
        end
    endgenerate

endmodule

// File: rtl/otp_seq_target.sv
module otp_seq_target
    import otp_tgt_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int DW          = 8,
    parameter bit WRAP        = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  logic          ctr_clear,
    input  logic          ctr_step,
    input  logic          read_n,
    input  logic          burn_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);
    localparam int AW = $clog2(DEPTH);

    port_evt_t     evt;
    logic [DW-1:0] wdata;
    logic [AW-1:0] addr;
    logic          we;
    logic          up_q;

    otp_port_sync #(.STAGES(SYNC_STAGES), .DW(DW)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_en),
        .clr_i    (ctr_clear),
        .step_i   (ctr_step),
        .rd_n_i   (read_n),
        .burn_n_i (burn_n),
        .din      (bus_in),
        .evt      (evt),
        .wdata    (wdata)
    );

    otp_addr_ctr #(.DEPTH(DEPTH), .WRAP(WRAP), .AW(AW)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (evt.clr_rise),
        .step (evt.step_rise),
        .addr (addr)
    );

    // a program edge is dropped while the target itself drives the bus
    assign we = evt.burn_done & ~evt.rd_act;

    otp_cell_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_cells (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (bus_out)
    );

    assign bus_oe = evt.rd_act;

    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    assert_oe_gated_R7: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> mode_en);

    assert_hold_off_R7: assert property (@(posedge clk) disable iff (rst)
        (up_q && !mode_en) |=> addr == $past(addr));

    assert_read_safe_R9: assert property (@(posedge clk) disable iff (rst)
        (up_q && bus_oe && !evt.step_rise && !evt.clr_rise) |=> $stable(bus_out));

    assert_reset_oe_R1: assert property (@(posedge clk)
        rst |=> !bus_oe);

endmodule

// File: tb/tb_otp_seq_target.sv
`timescale 1ns/1ps
module tb_otp_seq_target;

    localparam int DEPTH = 8;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_en = 1'b0;
    logic          ctr_clear = 1'b0;
    logic          ctr_step = 1'b0;
    logic          read_n = 1'b1;
    logic          burn_n = 1'b1;
    logic [DW-1:0] bus_in = '1;
    logic [DW-1:0] out_w, out_s;
    logic          oe_w, oe_s;

    always #2.5 clk = ~clk;

    otp_seq_target #(.DEPTH(DEPTH), .DW(DW), .WRAP(1'b1), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .ctr_clear(ctr_clear),
        .ctr_step(ctr_step), .read_n(read_n), .burn_n(burn_n),
        .bus_in(bus_in), .bus_out(out_w), .bus_oe(oe_w)
    );

    otp_seq_target #(.DEPTH(DEPTH), .DW(DW), .WRAP(1'b0), .SYNC_STAGES(2)) dut_sat (
        .clk(clk), .rst(rst), .mode_en(mode_en), .ctr_clear(ctr_clear),
        .ctr_step(ctr_step), .read_n(read_n), .burn_n(burn_n),
        .bus_in(bus_in), .bus_out(out_s), .bus_oe(oe_s)
    );

    typedef struct {
        logic [DW-1:0] dw;
        logic [DW-1:0] ds;
        bit            oe;
        bit            cmp_data;
        string         tag;
    } exp_t;

    exp_t exp_q [$];
    bit   smp = 1'b0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_step();
        ctr_step = 1'b1; wait_n(4); ctr_step = 1'b0; wait_n(4);
    endtask

    task automatic pulse_clear();
        ctr_clear = 1'b1; wait_n(4); ctr_clear = 1'b0; wait_n(4);
    endtask

    task automatic prog(logic [DW-1:0] v);
        bus_in = v; wait_n(4);
        burn_n = 1'b0; wait_n(6);
        burn_n = 1'b1; wait_n(5);
    endtask

    task automatic post(logic [DW-1:0] ew, logic [DW-1:0] es, bit oe, bit cd, string tag);
        exp_t it;
        it.dw = ew; it.ds = es; it.oe = oe; it.cmp_data = cd; it.tag = tag;
        exp_q.push_back(it);
        smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
    endtask

    task automatic rd(logic [DW-1:0] ew, logic [DW-1:0] es, string tag);
        read_n = 1'b0; wait_n(6);
        post(ew, es, 1'b1, 1'b1, tag);
        read_n = 1'b1; wait_n(4);
    endtask

    task automatic rd_off(string tag);
        read_n = 1'b0; wait_n(6);
        post('0, '0, 1'b0, 1'b0, tag);
        read_n = 1'b1; wait_n(4);
    endtask

    // monitor: pops expectations and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (smp && exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (oe_w !== it.oe || oe_s !== it.oe) begin
                    fails++;
                    $display("FAIL %s oe: actual %b/%b expected %b", it.tag, oe_w, oe_s, it.oe);
                end
                if (it.cmp_data) begin
                    checks++;
                    if (out_w !== it.dw || out_s !== it.ds) begin
                        fails++;
                        $display("FAIL %s data: actual %h/%h expected %h/%h",
                                 it.tag, out_w, out_s, it.dw, it.ds);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(3);
        rd_off("R1 R7 disabled after reset");
        mode_en = 1'b1;
        wait_n(3);
        rd(8'hFF, 8'hFF, "R1 erased cell 0");
        post('0, '0, 1'b0, 1'b0, "R5 read high idle");
        prog(8'hA5);
        rd(8'hA5, 8'hA5, "R6 first burn");
        prog(8'hF0);
        rd(8'hA0, 8'hA0, "R6 no 0 to 1");
        for (int i = 1; i < DEPTH; i++) begin
            pulse_step();
            prog(8'h10 + 8'(i));
        end
        rd(8'h17, 8'h17, "R3 last address");
        pulse_step();
        rd(8'hA0, 8'h17, "R4 wrap vs saturate");
        pulse_clear();
        rd(8'hA0, 8'hA0, "R2 clear");
        pulse_step();
        rd(8'h11, 8'h11, "R3 step 1");
        pulse_step();
        rd(8'h12, 8'h12, "R3 step 2");
        pulse_step();
        ctr_clear = 1'b1; ctr_step = 1'b1; wait_n(4);
        ctr_clear = 1'b0; ctr_step = 1'b0; wait_n(4);
        rd(8'hA0, 8'hA0, "R8 clear over step");
        read_n = 1'b0; bus_in = 8'h00; wait_n(4);
        burn_n = 1'b0; wait_n(6); burn_n = 1'b1; wait_n(5);
        read_n = 1'b1; wait_n(4);
        rd(8'hA0, 8'hA0, "R9 burn during read");
        pulse_step();
        pulse_step();
        mode_en = 1'b0;
        wait_n(2);
        pulse_step();
        prog(8'h00);
        pulse_clear();
        rd_off("R7 no drive when disabled");
        mode_en = 1'b1;
        wait_n(3);
        rd(8'h12, 8'h12, "R7 actions ignored");
        prog(8'h0F);
        rd(8'h02, 8'h02, "R6 partial clear");
        wait_n(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule